// File: doc/BRIEF.md
# Ping-Pong Bulk OUT Receive Buffer with Interrupt Flags

This block is the receive side of a bulk OUT endpoint in a USB device controller. It holds two packet banks. The serial-engine side writes received bytes into one bank. The CPU drains the other bank through a byte read port that also shows how many bytes remain. When the CPU bank is empty and the serial bank holds a finished good packet, the banks trade places on the next clock. The CPU bank then holds the new packet, and its remaining-length count is loaded with the packet length.

Four sticky status flags report the following events:

- data ready for the CPU;
- an OUT token that was refused with NAK;
- an arrived zero-length packet;
- both banks occupied.

Software cannot write the status flags directly. It clears them through a separate clear write, where a 0 in a bit position clears that flag. The interrupt output is formed from the flags under a per-bit enable mask. It is also held high across the one-clock gap while a waiting packet moves across to the CPU side.

Packet decoding, CRC checking and handshakes happen elsewhere. This block sees only three strobes: good end of packet, zero-length packet, and NAK returned. A good-packet strobe with no bytes written since the last swap is ignored.

Top module: `bulk_out_pingpong`

## Requirements
- R1: After reset, `status` is 0x00, `cpu_len` is 0 and `irq` is 0. Bits 7..4 of `status` always read 0.
- R2: After bytes are written and `sie_pkt_good` is pulsed into an empty buffer, two clocks later `cpu_len` equals the byte count and `status` bit 0 is set. `cpu_rd_data` shows the bytes in write order and advances one byte per `cpu_rd_en` clock.
- R3: `status` bit 0 clears on the clock after the read that brings `cpu_len` to 0.
- R4: `status` bit 3 sets on the clock after a good packet is accepted while the CPU bank holds data. It clears when the banks swap.
- R5: When the CPU bank is empty and the serial bank holds a good packet, the banks swap on the next clock. The swap reloads `cpu_len` with the packet length and sets `status` bit 0 again.
- R6: While the serial bank is full, written bytes are ignored. A `sie_pkt_good` or `sie_pkt_zlp` arriving then is dropped and sets `status` bit 1. `sie_nak` also sets bit 1 on the next clock.
- R7: A `sie_pkt_zlp` arriving while the CPU bank is empty sets `status` bit 2 on the next clock and leaves bit 0 clear.
- R8: A `sie_pkt_zlp` arriving while the CPU bank holds data does not change `status` at once. Bit 2 sets on the clock after that bank is drained.
- R9: When `clr_wr_en` is high, each 0 in `clr_wr_data[3:0]` clears the matching `status` bit on the next clock, and each 1 leaves it unchanged. A hardware set in the same clock wins.
- R10: `irq` is combinational and equals OR(`status[3:0]` & `int_mask`) OR (`int_mask[0]` & serial bank full). It therefore stays high while the CPU drains its bank and a packet waits on the serial side.
- R11: A bank stores at most DEPTH (64) bytes. Further writes are dropped, and `cpu_len` never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sie_wr_en | input | 1 | Write one received byte into the serial bank |
| sie_wr_data | input | 8 | Received byte |
| sie_pkt_good | input | 1 | Strobe: packet completed with good CRC |
| sie_pkt_zlp | input | 1 | Strobe: zero-length packet received |
| sie_nak | input | 1 | Strobe: OUT token answered with NAK |
| cpu_rd_en | input | 1 | Consume one byte from the CPU bank |
| cpu_rd_data | output | 8 | Byte at the CPU read position |
| cpu_len | output | 7 | Bytes remaining in the CPU bank |
| clr_wr_en | input | 1 | Write to the clear register |
| clr_wr_data | input | 4 | Clear pattern; a 0 clears the flag |
| int_mask | input | 4 | Per-flag interrupt enable |
| status | output | 8 | {4'b0, both-full, null, NAK, data} |
| irq | output | 1 | Interrupt request |
| sie_busy | output | 1 | Serial bank holds an unswapped packet |

## Verification
Each result has a fixed due cycle:

- Flag sets and clears, and the `cpu_len` decrement, are visible one clock after the stimulus.
- A packet reaching an empty CPU bank and a swap after draining the bank both take two clocks, because the serial bank is marked full first and the swap follows.
- `cpu_rd_data` and `irq` are combinational, so they are checked in the same cycle they are driven.

Each stimulus task queues its expected values tagged with the cycle number when they are due. The monitor compares only the entries whose due cycle matches the current cycle. It samples shortly after the falling edge, so the clocking edge is never involved in a comparison.

// File: rtl/bulk_out_pingpong.sv
module bulk_out_pingpong #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sie_wr_en,
  input  logic [DW-1:0] sie_wr_data,
  input  logic          sie_pkt_good,
  input  logic          sie_pkt_zlp,
  input  logic          sie_nak,
  input  logic          cpu_rd_en,
  output logic [DW-1:0] cpu_rd_data,
  output logic [LW-1:0] cpu_len,
  input  logic          clr_wr_en,
  input  logic [3:0]    clr_wr_data,
  input  logic [3:0]    int_mask,
  output logic [7:0]    status,
  output logic          irq,
  output logic          sie_busy
);

  logic [DW-1:0] mem [2][DEPTH];
  logic          cpu_bank;
  logic [AW-1:0] rd_ptr;
  logic [LW-1:0] sie_cnt;
  logic          sie_full;
  logic          null_pend;
  logic [3:0]    flags;

  wire swap    = sie_full && (cpu_len == '0);
  wire rd_fire = cpu_rd_en && (cpu_len != '0);
  wire drain   = rd_fire && (cpu_len == LW'(1));
  wire accept  = sie_pkt_good && !sie_full && (sie_cnt != '0);
  wire drop    = (sie_pkt_good || sie_pkt_zlp) && sie_full;
  wire zlp_ok  = sie_pkt_zlp && !sie_full;
  wire wr_fire = sie_wr_en && !sie_full && (sie_cnt < LW'(DEPTH));

  logic [3:0] set_hw, clr_hw, clr_sw;

  always_comb begin
    set_hw[0] = swap;
    set_hw[1] = sie_nak || drop;
    set_hw[2] = (zlp_ok && ((cpu_len == '0) || drain)) || (drain && null_pend);
    set_hw[3] = accept && (cpu_len != '0);
    clr_hw    = {swap, 2'b00, drain};
    clr_sw    = clr_wr_en ? ~clr_wr_data : 4'b0000;
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem[~cpu_bank][sie_cnt[AW-1:0]] <= sie_wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_bank  <= 1'b0;
      rd_ptr    <= '0;
      cpu_len   <= '0;
      sie_cnt   <= '0;
      sie_full  <= 1'b0;
      null_pend <= 1'b0;
      flags     <= '0;
    end else begin
      if (swap) begin
        cpu_bank <= ~cpu_bank;
        cpu_len  <= sie_cnt;
        rd_ptr   <= '0;
        sie_cnt  <= '0;
        sie_full <= 1'b0;
      end else begin
        if (rd_fire) begin
          cpu_len <= cpu_len - LW'(1);
          rd_ptr  <= rd_ptr + AW'(1);
        end
        if (wr_fire) sie_cnt  <= sie_cnt + LW'(1);
        if (accept)  sie_full <= 1'b1;
      end
      null_pend <= drain ? 1'b0 : (null_pend || (zlp_ok && (cpu_len != '0)));
      flags     <= (flags & ~clr_hw & ~clr_sw) | set_hw;
    end
  end

  assign cpu_rd_data = mem[cpu_bank][rd_ptr];
  assign status      = {4'b0000, flags};
  assign irq         = (|(flags & int_mask)) || (int_mask[0] && sie_full);
  assign sie_busy    = sie_full;

  // R3
  drain_clears_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_en && cpu_len == LW'(1)) |=> (cpu_len == '0 && !status[0]));

  // R5
  swap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_busy && cpu_len == '0) |=> (cpu_len != '0 && status[0] && !status[3] && !sie_busy));

  // R6
  drop_sets_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_busy && (sie_pkt_good || sie_pkt_zlp)) |=> status[1]);

  // R7
  zlp_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_pkt_zlp && !sie_busy && cpu_len == '0) |=> status[2]);

  // R11
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_len <= LW'(DEPTH));

endmodule

// File: tb/bulk_out_pingpong_tb.sv
module bulk_out_pingpong_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic sie_wr_en = 0, sie_pkt_good = 0, sie_pkt_zlp = 0, sie_nak = 0, cpu_rd_en = 0, clr_wr_en = 0;
  logic [7:0] sie_wr_data = '0;
  logic [3:0] clr_wr_data = '0, int_mask = 4'hF;
  logic [7:0] cpu_rd_data, status;
  logic [LW-1:0] cpu_len;
  logic irq, sie_busy;

  bulk_out_pingpong #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .sie_wr_en(sie_wr_en), .sie_wr_data(sie_wr_data),
    .sie_pkt_good(sie_pkt_good), .sie_pkt_zlp(sie_pkt_zlp), .sie_nak(sie_nak),
    .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data), .cpu_len(cpu_len),
    .clr_wr_en(clr_wr_en), .clr_wr_data(clr_wr_data), .int_mask(int_mask),
    .status(status), .irq(irq), .sie_busy(sie_busy));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; int kind; logic [7:0] exp; string req; } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic expect_at(int dly, int kind, logic [7:0] v, string req);
    item_t it;
    it.due = cyc + dly; it.kind = kind; it.exp = v; it.req = req;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    #1;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        logic [7:0] act;
        case (q[i].kind)
          0: act = status;
          1: act = 8'(cpu_len);
          2: act = {7'b0, irq};
          default: act = cpu_rd_data;
        endcase
        n_chk++;
        if (act !== q[i].exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", q[i].req, q[i].kind, act, q[i].exp);
        end
        q.delete(i);
      end
    end
  end

  task automatic quiet();
    sie_wr_en = 0; sie_pkt_good = 0; sie_pkt_zlp = 0; sie_nak = 0; cpu_rd_en = 0; clr_wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); quiet(); end
  endtask

  task automatic put_bytes(logic [7:0] base, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); quiet(); sie_wr_en = 1; sie_wr_data = base + 8'(i);
    end
  endtask

  task automatic pulse_good();
    @(negedge clk); quiet(); sie_pkt_good = 1;
  endtask

  task automatic pulse_zlp();
    @(negedge clk); quiet(); sie_pkt_zlp = 1;
  endtask

  task automatic pulse_nak();
    @(negedge clk); quiet(); sie_nak = 1;
  endtask

  task automatic write_clr(logic [3:0] d);
    @(negedge clk); quiet(); clr_wr_en = 1; clr_wr_data = d;
  endtask

  task automatic read_byte(logic [7:0] exp, string req);
    @(negedge clk); quiet(); cpu_rd_en = 1; expect_at(0, 3, exp, req);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    expect_at(0, 0, 8'h00, "R1 status"); expect_at(0, 1, 8'h00, "R1 len"); expect_at(0, 2, 8'h00, "R1 irq");

    // R2 first packet into empty buffer
    put_bytes(8'hA0, 4); pulse_good();
    expect_at(2, 0, 8'h01, "R2 data flag"); expect_at(2, 1, 8'd4, "R2 len");
    idle(3);
    expect_at(0, 2, 8'h01, "R10 irq on data");

    // R4 second packet while CPU bank full
    put_bytes(8'hB0, 3); pulse_good();
    expect_at(1, 0, 8'h09, "R4 both full");

    // R6 third packet dropped
    put_bytes(8'hC0, 2); pulse_good();
    expect_at(1, 0, 8'h0B, "R6 drop NAK");

    // R9 clear NAK only
    write_clr(4'b1101);
    expect_at(1, 0, 8'h09, "R9 clear NAK");

    // R2/R3/R5/R10 drain CPU bank, swap follows
    read_byte(8'hA0, "R2 byte0"); expect_at(1, 1, 8'd3, "R2 len dec");
    read_byte(8'hA1, "R2 byte1");
    read_byte(8'hA2, "R2 byte2");
    @(negedge clk); quiet(); int_mask = 4'b0001; cpu_rd_en = 1;
    expect_at(0, 3, 8'hA3, "R2 byte3");
    expect_at(1, 0, 8'h08, "R3 data clears");
    expect_at(1, 2, 8'h01, "R10 irq held across gap");
    expect_at(2, 0, 8'h01, "R5 swap sets data, R4 full clears");
    expect_at(2, 1, 8'd3, "R5 len reload");
    idle(2);
    int_mask = 4'hF;

    // R6 bytes written while full were ignored: second packet is B0..B2
    read_byte(8'hB0, "R6 kept B0");
    read_byte(8'hB1, "R6 kept B1");
    read_byte(8'hB2, "R6 kept B2");
    expect_at(1, 0, 8'h00, "R3 empty"); expect_at(1, 2, 8'h00, "R10 irq low");
    idle(2);

    // R7 ZLP into empty buffer
    pulse_zlp();
    expect_at(1, 0, 8'h04, "R7 null flag");
    idle(1);
    write_clr(4'b1011);
    expect_at(1, 0, 8'h00, "R9 clear null");

    // R8 deferred null
    put_bytes(8'hD0, 2); pulse_good();
    idle(2);
    pulse_zlp();
    expect_at(1, 0, 8'h01, "R8 null deferred");
    read_byte(8'hD0, "R8 byte0");
    read_byte(8'hD1, "R8 byte1");
    expect_at(1, 0, 8'h04, "R8 null after drain");
    write_clr(4'b1011);
    idle(1);

    // R6 sie_nak; R9 writing ones leaves flag
    pulse_nak();
    expect_at(1, 0, 8'h02, "R6 nak strobe");
    write_clr(4'b1111);
    expect_at(1, 0, 8'h02, "R9 ones no effect");
    idle(2);
    // R10 mask
    @(negedge clk); int_mask = 4'b1101;
    expect_at(0, 2, 8'h00, "R10 masked");
    @(negedge clk); int_mask = 4'b0010;
    expect_at(0, 2, 8'h01, "R10 unmasked");
    write_clr(4'b1101);
    expect_at(1, 0, 8'h00, "R9 clear nak");
    idle(1);
    int_mask = 4'hF;

    // R11 overflow cap
    put_bytes(8'h00, DEPTH + 2); pulse_good();
    expect_at(2, 1, 8'(DEPTH), "R11 len cap");
    idle(3);
    for (int i = 0; i < DEPTH; i++) read_byte(8'(i), "R11 byte");
    expect_at(1, 1, 8'h00, "R11 drained");
    expect_at(1, 0, 8'h00, "R3 final status");
    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule